// File: doc/BRIEF.md
# Flash Instruction Fetch Accelerator

This block sits between the instruction port of a processor and a slow, burst-capable flash array. The processor raises a request with a word address and holds it until the block acknowledges it. The 32-bit instruction word is valid in the same cycle as the acknowledge. The processor may present the next address in the following cycle. A small prefetch queue keeps reading ahead from flash whenever there is room in the queue, so straight-line code runs at one word per clock.

Any request whose address is not the successor of the last acknowledged word counts as a redirect. A redirect empties the queue and restarts the flash burst at the new address. A branch-target store of 15 entries remembers the opening eight words of recent redirect targets. On a repeat redirect it hands those eight words over directly. Meanwhile the flash burst is restarted eight words further on, so the refill delay is hidden. The flash array here is a behavioural model with a parameterised first-access delay followed by one beat per clock. Word `a` of the model holds `{~a[15:0], a[15:0]}`.

Top module: `fetch_accel`

## Requirements
- R1: After a synchronous reset, `cpu_ack` stays low while no request is made. The store and the queue are empty, so the first request is a redirect that misses.
- R2: Every acknowledged word equals the flash content `{~a[15:0], a[15:0]}` of the requested word address `a`.
- R3: A redirect that misses in the store receives no acknowledge for exactly ACC_LAT cycles, counting the request cycle. The acknowledge arrives in the next cycle (4 cycles of stall by default).
- R4: After the first word of a run, sequential requests are acknowledged in their first cycle with no stall. This also holds after the processor pauses long enough for the queue (DEPTH words) to fill and the burst to halt.
- R5: A redirect to a target held in the store is acknowledged in its request cycle. The next seven sequential words also come from the store with no stall, and the ninth word and later ones arrive with no stall as long as ACC_LAT is at most 8.
- R6: A missed target gets an entry that becomes usable only after all eight of its opening words have been captured from flash. A redirect before capture completes abandons the entry, so a later redirect to that target misses again.
- R7: A new entry takes the lowest-numbered invalid slot. When every slot is valid, slots are replaced in round-robin order starting from slot 0 after reset. The round-robin pointer advances only on a replacement.
- R8: A one-cycle pulse on `bc_clear` invalidates every entry, so the next redirect to any earlier target misses.
- R9: The flash burst pauses while the queue holds DEPTH words and never writes into a full queue. Words are delivered in address order after the pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bc_clear | input | 1 | Invalidate every branch-target entry |
| cpu_req | input | 1 | Fetch request, held until acknowledged |
| cpu_addr | input | AW | Word address of the requested instruction |
| cpu_ack | output | 1 | Request served this cycle |
| cpu_data | output | 32 | Instruction word, valid with `cpu_ack` |

## Verification
Every internal fault in this block shows up at the ports within one redirect, in one of two forms: a wrong stall count or a wrong data word. A store that loses or keeps an entry wrongly turns a zero-stall redirect into an ACC_LAT-cycle stall, or the reverse, on the very next redirect to that target. A queue or burst restart that is off by one word returns the content of a neighbouring address in the cycle it is acknowledged. Replacement faults show up as a hit or a miss on a specific target a few redirects after the store is full.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int ADDR_W = 16;
  localparam int WORD_W = 32;

  // behavioural flash content: upper half inverted copy of the address
  function automatic logic [WORD_W-1:0] fa_content(input logic [15:0] a);
    return {~a, a};
  endfunction
endpackage

// File: rtl/fa_flash.sv
module fa_flash #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int ACC_LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [AW-1:0] restart_addr,
  input  logic          take,
  output logic          beat,
  output logic [DW-1:0] beat_data
);
  localparam int CW = $clog2(ACC_LAT + 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;

  // a restart in the same cycle discards the beat
  assign beat      = active && (cnt == '0) && take && !restart;
  assign beat_data = DW'(fa_pkg::fa_content(16'(addr)));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      addr   <= '0;
    end else if (restart) begin
      active <= 1'b1;
      cnt    <= CW'(ACC_LAT - 2);
      addr   <= restart_addr;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (beat) begin
      addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/fa_pfq.sv
module fa_pfq #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [AW-1:0] head_addr,
  output logic          nonempty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_data = mem[rp];
  assign nonempty  = (cnt != '0);
  assign full      = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt       <= '0;
      wp        <= '0;
      rp        <= '0;
      head_addr <= rst ? '0 : flush_addr;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop) begin
        rp        <= nxt(rp);
        head_addr <= head_addr + 1'b1;
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst || flush)
    push |-> (!full || pop));
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst || flush)
    pop |-> nonempty);
endmodule

// File: rtl/fa_bcache.sv
module fa_bcache #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NENT = 15,
  parameter int NW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inv_all,
  input  logic [AW-1:0]            lk_addr,
  output logic                     lk_hit,
  output logic [$clog2(NENT)-1:0]  lk_idx,
  input  logic [$clog2(NENT)-1:0]  rd_idx,
  input  logic [$clog2(NW)-1:0]    rd_word,
  output logic [DW-1:0]            rd_data,
  input  logic                     alloc,
  input  logic [AW-1:0]            alloc_tag,
  output logic [$clog2(NENT)-1:0]  alloc_idx,
  input  logic                     wr_en,
  input  logic [$clog2(NENT)-1:0]  wr_idx,
  input  logic [$clog2(NW)-1:0]    wr_word,
  input  logic [DW-1:0]            wr_data,
  input  logic                     wr_done
);
  localparam int EW = $clog2(NENT);
  localparam int WW = $clog2(NW);
  localparam int MD = NENT * NW;

  logic [AW-1:0]   tag [NENT];
  logic [NENT-1:0] vld;
  logic [NENT-1:0] match;
  logic [EW-1:0]   rr;
  logic            free_found;
  logic [DW-1:0]   mem [MD];

  always_comb begin
    lk_idx = '0;
    for (int e = NENT - 1; e >= 0; e--) begin
      match[e] = vld[e] && (tag[e] == lk_addr);
      if (match[e]) lk_idx = EW'(e);
    end
  end
  assign lk_hit = |match;

  always_comb begin
    free_found = 1'b0;
    alloc_idx  = rr;
    for (int e = NENT - 1; e >= 0; e--) begin
      if (!vld[e]) begin
        free_found = 1'b1;
        alloc_idx  = EW'(e);
      end
    end
  end

  assign rd_data = mem[{rd_idx, rd_word}];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_idx, wr_word}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (alloc) tag[alloc_idx] <= alloc_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      rr  <= '0;
    end else if (inv_all) begin
      vld <= '0;
    end else begin
      if (alloc) begin
        vld[alloc_idx] <= 1'b0;
        if (!free_found) rr <= (rr == EW'(NENT - 1)) ? '0 : rr + 1'b1;
      end
      if (wr_en && wr_done) vld[wr_idx] <= 1'b1;
    end
  end

  a_r6_single_match: assert property (@(posedge clk) disable iff (rst)
    $countones(match) <= 1);
  a_r7_free_first: assert property (@(posedge clk) disable iff (rst)
    (alloc && !(&vld)) |-> !vld[alloc_idx]);
endmodule

// File: rtl/fetch_accel.sv
module fetch_accel #(
  parameter int AW = fa_pkg::ADDR_W,
  parameter int DEPTH = 4,
  parameter int NENT = 15,
  parameter int NW = 8,
  parameter int ACC_LAT = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bc_clear,
  input  logic                      cpu_req,
  input  logic [AW-1:0]             cpu_addr,
  output logic                      cpu_ack,
  output logic [fa_pkg::WORD_W-1:0] cpu_data
);
  localparam int DW = fa_pkg::WORD_W;
  localparam int EW = $clog2(NENT);
  localparam int WW = $clog2(NW);

  logic          started;
  logic [AW-1:0] nxt_addr;
  logic          rp_on;
  logic [EW-1:0] rp_ent;
  logic [WW-1:0] rp_word;
  logic          cap_on;
  logic [EW-1:0] cap_ent;
  logic [WW-1:0] cap_word;

  logic          is_br, hit_br, rp_serve, seq_serve, alloc;
  logic          lk_hit;
  logic [EW-1:0] lk_idx, alloc_idx, rd_idx;
  logic [WW-1:0] rd_word;
  logic [DW-1:0] rd_data;
  logic          beat, wr_en, wr_done;
  logic [DW-1:0] beat_data;
  logic [AW-1:0] restart_addr, q_head_addr;
  logic [DW-1:0] q_head_data;
  logic          q_ne, q_full;

  assign is_br     = cpu_req && (!started || cpu_addr != nxt_addr);
  assign hit_br    = is_br && lk_hit;
  assign rp_serve  = cpu_req && !is_br && rp_on;
  assign seq_serve = cpu_req && !is_br && !rp_on && q_ne;
  assign alloc     = is_br && !lk_hit;

  assign cpu_ack   = hit_br || rp_serve || seq_serve;
  assign rd_idx    = hit_br ? lk_idx : rp_ent;
  assign rd_word   = hit_br ? '0 : rp_word;
  assign cpu_data  = (hit_br || rp_serve) ? rd_data : q_head_data;

  assign restart_addr = hit_br ? cpu_addr + AW'(NW) : cpu_addr;
  assign wr_en        = cap_on && beat && !bc_clear;
  assign wr_done      = (cap_word == WW'(NW - 1));

  fa_flash #(.AW(AW), .DW(DW), .ACC_LAT(ACC_LAT)) u_flash (
    .clk(clk), .rst(rst), .restart(is_br), .restart_addr(restart_addr),
    .take(!q_full), .beat(beat), .beat_data(beat_data)
  );

  fa_pfq #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_pfq (
    .clk(clk), .rst(rst), .flush(is_br), .flush_addr(restart_addr),
    .push(beat), .push_data(beat_data), .pop(seq_serve),
    .head_data(q_head_data), .head_addr(q_head_addr),
    .nonempty(q_ne), .full(q_full)
  );

  fa_bcache #(.AW(AW), .DW(DW), .NENT(NENT), .NW(NW)) u_bc (
    .clk(clk), .rst(rst), .inv_all(bc_clear),
    .lk_addr(cpu_addr), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .rd_idx(rd_idx), .rd_word(rd_word), .rd_data(rd_data),
    .alloc(alloc), .alloc_tag(cpu_addr), .alloc_idx(alloc_idx),
    .wr_en(wr_en), .wr_idx(cap_ent), .wr_word(cap_word),
    .wr_data(beat_data), .wr_done(wr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      started  <= 1'b0;
      nxt_addr <= '0;
      rp_on    <= 1'b0;
      rp_ent   <= '0;
      rp_word  <= '0;
      cap_on   <= 1'b0;
      cap_ent  <= '0;
      cap_word <= '0;
    end else begin
      if (is_br) started <= 1'b1;

      if (cpu_ack)    nxt_addr <= cpu_addr + 1'b1;
      else if (is_br) nxt_addr <= cpu_addr;

      if (hit_br) begin
        rp_on   <= 1'b1;
        rp_ent  <= lk_idx;
        rp_word <= WW'(1);
      end else if (is_br) begin
        rp_on <= 1'b0;
      end else if (rp_serve) begin
        rp_word <= rp_word + 1'b1;
        if (rp_word == WW'(NW - 1)) rp_on <= 1'b0;
      end

      if (alloc) begin
        cap_on   <= !bc_clear;
        cap_ent  <= alloc_idx;
        cap_word <= '0;
      end else if (hit_br || bc_clear) begin
        cap_on <= 1'b0;
      end else if (wr_en) begin
        cap_word <= cap_word + 1'b1;
        if (wr_done) cap_on <= 1'b0;
      end
    end
  end

  a_r2_head_match: assert property (@(posedge clk) disable iff (rst)
    seq_serve |-> (q_head_addr == cpu_addr));

  generate
    if (ACC_LAT <= NW) begin : g_refill_chk
      a_r5_refill_ready: assert property (@(posedge clk) disable iff (rst)
        (rp_serve && rp_word == WW'(NW - 1)) |=> q_ne);
    end
  endgenerate
endmodule

// File: tb/fetch_accel_test.sv
module fetch_accel_test;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bc_clear = 1'b0;
  logic        cpu_req = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_ack;
  logic [31:0] cpu_data;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  fetch_accel uut (
    .clk(clk), .rst(rst), .bc_clear(bc_clear), .cpu_req(cpu_req),
    .cpu_addr(cpu_addr), .cpu_ack(cpu_ack), .cpu_data(cpu_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cpu_req = 1'b0; bc_clear = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(cpu_ack == 1'b0, "R1 ack low after reset", cpu_ack, 0);
    @(posedge clk); #1;
  endtask

  // hold one request until acknowledged; returns stall cycles
  task automatic do_fetch(input logic [15:0] a, output int stalls);
    logic [31:0] exp;
    exp = {~a, a};
    stalls = 0;
    cpu_req = 1'b1; cpu_addr = a;
    forever begin
      @(negedge clk);
      if (cpu_ack) break;
      stalls++;
      if (stalls > 60) begin
        chk(1'b0, "R3 watchdog no ack", stalls, LAT);
        break;
      end
      @(posedge clk); #1;
    end
    if (cpu_ack) chk(cpu_data == exp, "R2 data", cpu_data, exp);
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic run(input logic [15:0] a, input int n, input int first, input string req);
    int st;
    for (int i = 0; i < n; i++) begin
      do_fetch(a + 16'(i), st);
      chk(st == ((i == 0) ? first : 0), req, st, (i == 0) ? first : 0);
    end
  endtask

  task automatic idle(input int n);
    cpu_req = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_cold_and_hit();
    run(16'h0100, 16, LAT, "R1 R3 R4 cold miss then stream");
    run(16'h0100, 12, 0, "R5 repeat target ninth word no stall");
  endtask

  task automatic t_miss_then_hit();
    run(16'h0200, 3, LAT, "R3 miss");
    run(16'h0100, 9, 0, "R5 hit after other miss");
    run(16'h0100, 3, 0, "R5 hit again");
    run(16'h0700, 2, LAT, "R3 branch out of replay misses");
  endtask

  task automatic t_abandon();
    run(16'h0300, 4, LAT, "R6 partial capture");
    run(16'h0400, 2, LAT, "R6 branch away");
    run(16'h0300, 1, LAT, "R6 abandoned entry misses");
  endtask

  task automatic t_queue_full();
    run(16'h0500, 2, LAT, "R9 start");
    idle(10);
    run(16'h0502, 14, 0, "R9 R4 resume after full queue");
  endtask

  task automatic t_clear();
    run(16'h0100, 1, 0, "R8 hit before clear");
    bc_clear = 1'b1;
    @(posedge clk); #1;
    bc_clear = 1'b0;
    run(16'h0200, 1, LAT, "R8 other target after clear");
    run(16'h0100, 1, LAT, "R8 miss after clear");
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int i = 0; i < 16; i++) run(16'h1000 + 16'(i * 64), 8, LAT, "R7 fill");
    run(16'h1000, 1, LAT, "R7 slot0 replaced");
    run(16'h1080, 1, 0, "R7 slot2 kept");
    run(16'h1040, 1, LAT, "R7 slot1 replaced next");
    run(16'h13C0, 1, 0, "R7 newest kept");
  endtask

  initial begin
    do_reset();
    t_cold_and_hit();
    t_miss_then_hit();
    t_abandon();
    t_queue_full();
    t_clear();
    t_round_robin();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule